// File: doc/BRIEF.md
# Keypad Polling and LED Scan Sequencer

This block scans a grid of classroom response keypads, one column at a time. It shares a byte-wide 2 KB static RAM with a host computer. A single host-control input decides who owns the RAM. While that input is high, the host reads and writes the RAM through its own port, and the sequencer's counters are held at zero. While the input is low, the sequencer owns the RAM and runs a fixed per-column program of ticks, each tick lasting `PHASES` clocks.

In each column the sequencer first fetches one LED byte for each of three substations and pulses that substation's latch. It then walks through 24 poll slots. In each slot it presents the slot number to the row multiplexers, samples the byte they return (one substation on each nibble) and stores it in RAM. It then dwells with the LEDs lit, blanks them in the final tick, and moves on to the next of 64 column codes. Only codes below 48 have hardware behind them.

Top module: `keypad_scan_seq`

## Requirements
- R1: While `host_ctl` is 1, a write on the host port stores `host_wdata` at `host_addr`, and `host_rdata` shows the byte at the address presented one clock earlier.
- R2: While `host_ctl` is 1, the sequencer's counters are held at zero. From the clock after it rises, `column` is 0, `led_latch` is 0, `led_blank` is 1, and the sequencer writes nothing. After release, scanning resumes at column 0, tick 0.
- R3: A column lasts `MINOR_LAST`+1 ticks of `PHASES` clocks each (793 ticks by default). `column` then increments and wraps from 63 to 0.
- R4: In ticks 0 to 2 of a live column, `led_latch` bit k pulses for one clock, one clock after the last clock of tick k. At the same time `led_data` takes the RAM byte at 1536 + 4·column + k, and it holds that value until the next pulse.
- R5: In tick 3+s, for s from 0 to 23, `poll_sel` equals s. Outside poll ticks it is 0. The sampled row byte is stored at RAM address 32·column + s.
- R6: The byte stored for a poll slot is the value of `row_in` during the first clock of that tick; later changes within the tick are ignored. The write strobe falls only in clock `PHASES`/2 of the tick, with the address held in the clock before and the clock after it.
- R7: `led_blank` is 0 from tick 0 through tick `MINOR_LAST`−1, and 1 in tick `MINOR_LAST`.
- R8: Columns 48 to 63 produce no latch pulse and no RAM write, so the LED region keeps its contents.
- R9: A synchronous active-high `rst` sets `column`, `poll_sel`, `led_latch` and `led_data` to 0 and `led_blank` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each tick is `PHASES` clocks |
| rst | input | 1 | Synchronous active-high reset |
| host_ctl | input | 1 | 1 = host owns the RAM and the counters are held |
| host_addr | input | 11 | Host RAM address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered RAM read data |
| row_in | input | 8 | Row byte from the multiplexers (two nibbles) |
| poll_sel | output | 5 | Poll slot driven to the row multiplexers |
| column | output | 6 | Active column index |
| led_data | output | 8 | LED byte presented to the substation latches |
| led_latch | output | 3 | One-hot latch pulse, bit k for substation k |
| led_blank | output | 1 | 1 = all LEDs off |

## Verification
The RAM is preloaded with an address-dependent pattern, so each latch pulse shows whether the right column and substation byte was fetched. The row input carries one value in the first clock of every poll tick and its complement afterwards; a sample taken at the wrong clock therefore shows up as an inverted byte on readback. Two scan passes use different row patterns, which separates columns that were rewritten after the wrap from those that were not. The scan runs through the unused columns 48 to 63 and the 63-to-0 wrap, and the host takes control in the middle of a column, which tests both the freeze and the restart at column 0.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;

  typedef enum logic [1:0] {
    TK_LIGHT,
    TK_POLL,
    TK_DWELL,
    TK_DARK
  } tick_kind_e;

  // Maps a tick number inside one column onto its kind of work.
  function automatic tick_kind_e classify(input int tick, input int n_light,
                                          input int n_poll, input int last);
    if (tick < n_light)               return TK_LIGHT;
    if (tick < n_light + n_poll)      return TK_POLL;
    if (tick == last)                 return TK_DARK;
    return TK_DWELL;
  endfunction

endpackage

// File: rtl/scan_timebase.sv
module scan_timebase #(
  parameter int PHASES     = 4,
  parameter int MINOR_LAST = 792,
  parameter int COL_W      = 6,
  parameter int PH_W       = $clog2(PHASES),
  parameter int MN_W       = $clog2(MINOR_LAST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [PH_W-1:0]  ph,
  output logic [MN_W-1:0]  minor,
  output logic [COL_W-1:0] col
);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ph    <= '0;
      minor <= '0;
      col   <= '0;
    end else if (ph == PH_W'(PHASES - 1)) begin
      ph <= '0;
      if (minor == MN_W'(MINOR_LAST)) begin
        minor <= '0;
        col   <= col + 1'b1;
      end else begin
        minor <= minor + 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

endmodule

// File: rtl/scan_microcode.sv
module scan_microcode
  import keypad_scan_pkg::*;
#(
  parameter int PHASES     = 4,
  parameter int MINOR_LAST = 792,
  parameter int COL_W      = 6,
  parameter int COL_LIMIT  = 48,
  parameter int SUBST      = 3,
  parameter int SUBSUB     = 8,
  parameter int ADDR_W     = 11,
  parameter int PH_W       = $clog2(PHASES),
  parameter int MN_W       = $clog2(MINOR_LAST + 1),
  parameter int SLOT_W     = $clog2(SUBST * SUBSUB),
  parameter int SUB_W      = $clog2(SUBST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [PH_W-1:0]   ph,
  input  logic [MN_W-1:0]   minor,
  input  logic [COL_W-1:0]  col,
  output logic [COL_W-1:0]  q_col,
  output logic [SLOT_W-1:0] q_slot,
  output logic [SUB_W-1:0]  q_sub,
  output logic              q_sample,
  output logic              q_we,
  output logic              q_latch,
  output logic              q_blank,
  output logic [ADDR_W-1:0] q_addr
);

  localparam int SLOTS    = SUBST * SUBSUB;
  localparam int LED_BASE = COL_LIMIT * (2 ** SLOT_W);

  tick_kind_e         kind;
  logic               live;
  logic [SLOT_W-1:0]  slot_n;
  logic [SUB_W-1:0]   sub_n;
  logic [ADDR_W-1:0]  addr_n;

  always_comb begin
    kind   = classify(int'(minor), SUBST, SLOTS, MINOR_LAST);
    live   = int'(col) < COL_LIMIT;
    slot_n = '0;
    sub_n  = '0;
    addr_n = '0;
    if (kind == TK_POLL) begin
      slot_n = SLOT_W'(int'(minor) - SUBST);
      addr_n = ADDR_W'({col, slot_n});
    end else if (kind == TK_LIGHT) begin
      sub_n  = SUB_W'(minor);
      addr_n = ADDR_W'(LED_BASE) + ADDR_W'({col, sub_n});
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      q_col    <= '0;
      q_slot   <= '0;
      q_sub    <= '0;
      q_sample <= 1'b0;
      q_we     <= 1'b0;
      q_latch  <= 1'b0;
      q_blank  <= 1'b1;
      q_addr   <= '0;
    end else begin
      q_col    <= col;
      q_slot   <= slot_n;
      q_sub    <= sub_n;
      q_sample <= (kind == TK_POLL) && (ph == '0);
      q_we     <= (kind == TK_POLL) && (ph == PH_W'(PHASES / 2)) && live;
      q_latch  <= (kind == TK_LIGHT) && (ph == PH_W'(PHASES - 1)) && live;
      q_blank  <= (kind == TK_DARK);
      q_addr   <= addr_n;
    end
  end

endmodule

// File: rtl/scan_ram.sv
module scan_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [2**ADDR_W];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/keypad_scan_seq.sv
module keypad_scan_seq #(
  parameter int PHASES     = 4,
  parameter int MINOR_LAST = 792,
  parameter int COL_W      = 6,
  parameter int COL_LIMIT  = 48,
  parameter int SUBST      = 3,
  parameter int SUBSUB     = 8,
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = $clog2(SUBST * SUBSUB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_ctl,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] row_in,
  output logic [SLOT_W-1:0] poll_sel,
  output logic [COL_W-1:0]  column,
  output logic [DATA_W-1:0] led_data,
  output logic [SUBST-1:0]  led_latch,
  output logic              led_blank
);

  localparam int PH_W  = $clog2(PHASES);
  localparam int MN_W  = $clog2(MINOR_LAST + 1);
  localparam int SUB_W = $clog2(SUBST);

  logic [PH_W-1:0]   ph;
  logic [MN_W-1:0]   minor;
  logic [COL_W-1:0]  col;
  logic [SUB_W-1:0]  seq_sub;
  logic              seq_sample, seq_we, seq_latch;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] samp_q;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  scan_timebase #(
    .PHASES(PHASES), .MINOR_LAST(MINOR_LAST), .COL_W(COL_W),
    .PH_W(PH_W), .MN_W(MN_W)
  ) u_time (
    .clk(clk), .rst(rst), .hold(host_ctl),
    .ph(ph), .minor(minor), .col(col)
  );

  scan_microcode #(
    .PHASES(PHASES), .MINOR_LAST(MINOR_LAST), .COL_W(COL_W),
    .COL_LIMIT(COL_LIMIT), .SUBST(SUBST), .SUBSUB(SUBSUB), .ADDR_W(ADDR_W),
    .PH_W(PH_W), .MN_W(MN_W), .SLOT_W(SLOT_W), .SUB_W(SUB_W)
  ) u_ucode (
    .clk(clk), .rst(rst), .hold(host_ctl),
    .ph(ph), .minor(minor), .col(col),
    .q_col(column), .q_slot(poll_sel), .q_sub(seq_sub),
    .q_sample(seq_sample), .q_we(seq_we), .q_latch(seq_latch),
    .q_blank(led_blank), .q_addr(seq_addr)
  );

  // RAM port ownership follows host_ctl.
  always_comb begin
    ram_addr  = host_ctl ? host_addr  : seq_addr;
    ram_we    = host_ctl ? host_we    : seq_we;
    ram_wdata = host_ctl ? host_wdata : samp_q;
  end

  scan_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign host_rdata = ram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q    <= '0;
      led_latch <= '0;
      led_data  <= '0;
    end else begin
      if (seq_sample) samp_q <= row_in;
      if (seq_latch && !host_ctl) begin
        led_latch <= SUBST'(1) << seq_sub;
        led_data  <= ram_rdata;
      end else begin
        led_latch <= '0;
      end
    end
  end

endmodule

// File: rtl/keypad_scan_seq_chk.sv
module keypad_scan_seq_chk #(
  parameter int COL_W     = 6,
  parameter int SUBST     = 3,
  parameter int ADDR_W    = 11,
  parameter int COL_LIMIT = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ctl,
  input logic [COL_W-1:0]  column,
  input logic [SUBST-1:0]  led_latch,
  input logic              led_blank,
  input logic              seq_we,
  input logic [ADDR_W-1:0] ram_addr
);

  assert_host_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    host_ctl |=> (column == '0 && led_latch == '0 && led_blank && !seq_we));

  assert_col_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!host_ctl && !$past(host_ctl) && column != $past(column))
      |-> column == $past(column) + 1'b1);

  assert_latch_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(led_latch));

  assert_we_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_we && !host_ctl) |-> $stable(ram_addr));

  assert_we_single_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_we && !host_ctl) |=> (host_ctl || (!seq_we && $stable(ram_addr))));

  assert_latch_lit_R7: assert property (@(posedge clk) disable iff (rst)
    (led_latch != '0) |-> !led_blank);

  assert_we_live_R8: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> int'(column) < COL_LIMIT);

  assert_latch_live_R8: assert property (@(posedge clk) disable iff (rst)
    (led_latch != '0) |-> int'(column) < COL_LIMIT);

endmodule

bind keypad_scan_seq keypad_scan_seq_chk #(
  .COL_W(COL_W), .SUBST(SUBST), .ADDR_W(ADDR_W), .COL_LIMIT(COL_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .host_ctl(host_ctl), .column(column),
  .led_latch(led_latch), .led_blank(led_blank),
  .seq_we(seq_we), .ram_addr(ram_addr)
);

// File: tb/keypad_scan_seq_bench.sv
`timescale 1ns/1ps
module keypad_scan_seq_bench;

  localparam int P    = 4;
  localparam int ML   = 40;
  localparam int CL   = 48;
  localparam int LEDB = CL * 32;
  localparam int TPC  = (ML + 1) * P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_ctl = 1'b0;
  logic [10:0] host_addr = '0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [7:0]  row_in = '0;
  logic [4:0]  poll_sel;
  logic [5:0]  column;
  logic [7:0]  led_data;
  logic [2:0]  led_latch;
  logic        led_blank;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keypad_scan_seq #(.PHASES(P), .MINOR_LAST(ML), .COL_LIMIT(CL)) u_keypad_scan_seq (
    .clk(clk), .rst(rst), .host_ctl(host_ctl), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .row_in(row_in), .poll_sel(poll_sel), .column(column),
    .led_data(led_data), .led_latch(led_latch), .led_blank(led_blank)
  );

  // Behavioural reference state
  logic [7:0] mirror [2048];
  logic [7:0] salt = 8'h3C;
  int c_ph, c_mn, c_col;
  int s_col, s_slot, s_sub, s_ph;
  bit s_poll, s_we, s_latch, s_blank;
  logic [2:0] e_latch;
  logic [7:0] e_led;

  function automatic logic [7:0] rowfn(input int col, input int slot);
    return 8'(col * 29 + slot * 7) ^ salt;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      c_ph = 0; c_mn = 0; c_col = 0;
      s_col = 0; s_slot = 0; s_sub = 0; s_ph = 0;
      s_poll = 0; s_we = 0; s_latch = 0; s_blank = 1;
      e_latch = '0; e_led = '0;
    end else begin
      if (s_latch && !host_ctl) begin
        e_latch = 3'(1 << s_sub);
        e_led   = mirror[LEDB + s_col * 4 + s_sub];
      end else begin
        e_latch = '0;
      end
      if (s_we && !host_ctl) mirror[s_col * 32 + s_slot] = rowfn(s_col, s_slot);
      if (host_ctl) begin
        c_ph = 0; c_mn = 0; c_col = 0;
        s_col = 0; s_slot = 0; s_sub = 0; s_ph = 0;
        s_poll = 0; s_we = 0; s_latch = 0; s_blank = 1;
      end else begin
        s_col   = c_col;
        s_ph    = c_ph;
        s_poll  = (c_mn >= 3) && (c_mn < 27);
        s_slot  = s_poll ? c_mn - 3 : 0;
        s_sub   = (c_mn < 3) ? c_mn : 0;
        s_latch = (c_mn < 3) && (c_ph == P - 1) && (c_col < CL);
        s_we    = s_poll && (c_ph == P / 2) && (c_col < CL);
        s_blank = (c_mn == ML);
        c_ph++;
        if (c_ph == P) begin
          c_ph = 0;
          c_mn++;
          if (c_mn > ML) begin
            c_mn = 0;
            c_col = (c_col + 1) % 64;
          end
        end
      end
    end
  end

  // Row multiplexer stand-in plus per-clock comparison.
  always @(negedge clk) begin
    row_in <= (s_poll && s_ph == 0) ? rowfn(s_col, s_slot) : ~rowfn(s_col, s_slot);
    if (started && !done) begin
      if (rst) begin
        chk("R9", "column", 32'(column), 32'(s_col));
        chk("R9", "led_blank", 32'(led_blank), 32'(s_blank));
        chk("R9", "led_latch", 32'(led_latch), 32'(e_latch));
        chk("R9", "led_data", 32'(led_data), 32'(e_led));
        chk("R9", "poll_sel", 32'(poll_sel), 32'(s_slot));
      end else begin
        chk(host_ctl ? "R2" : "R3", "column", 32'(column), 32'(s_col));
        chk(host_ctl ? "R2" : "R7", "led_blank", 32'(led_blank), 32'(s_blank));
        chk((s_col >= CL) ? "R8" : "R4", "led_latch", 32'(led_latch), 32'(e_latch));
        chk("R4", "led_data", 32'(led_data), 32'(e_led));
        chk("R5", "poll_sel", 32'(poll_sel), 32'(s_slot));
      end
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = 11'(a);
    host_wdata = d;
    host_we    = 1'b1;
    mirror[a]  = d;
  endtask

  task automatic host_read(input string tag, input int a);
    @(negedge clk);
    host_we   = 1'b0;
    host_addr = 11'(a);
    @(negedge clk);
    chk(tag, "host_rdata", 32'(host_rdata), 32'(mirror[a]));
  endtask

  task automatic readback(input int lo, input int hi);
    for (int a = lo; a < hi; a++)
      host_read(a >= LEDB ? "R8" : "R6", a);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    host_ctl = 1'b1;
    for (int a = 0; a < 2048; a++)
      host_write(a, (a < LEDB) ? ~8'(a) : 8'(a * 13 + 1));
    @(negedge clk);
    host_we = 1'b0;
    host_read("R1", 0);
    host_read("R1", 777);
    host_read("R1", LEDB);
    host_read("R1", 2047);
    // First pass: every column code, including the wrap back to 0
    @(negedge clk);
    host_ctl = 1'b0;
    repeat (64 * TPC + 5 * TPC + TPC / 2) @(negedge clk);
    host_ctl = 1'b1;
    repeat (3) @(negedge clk);
    readback(0, 2048);
    // Second pass with a new row pattern, restarting at column 0
    salt = 8'hA5;
    @(negedge clk);
    host_ctl = 1'b0;
    repeat (2 * TPC + 30) @(negedge clk);
    host_ctl = 1'b1;
    repeat (2) @(negedge clk);
    readback(0, 3 * 32);
    readback(LEDB, LEDB + 16);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule